// File: doc/BRIEF.md
# Register-Controlled Byte SPI Master

This block is an SPI master that exchanges one byte at a time. Software controls it through eight byte-wide registers on a simple synchronous read/write port. Writing a byte to the data register queues it for transmission. When the core is enabled in master mode, the shift engine takes bytes from the transmit queue one at a time. For each byte it runs a full-duplex exchange of eight bits, most significant bit first. It then places the byte received on the input line into a receive queue. Software polls a status bit that shows whether the receive queue is empty, and a read of the data register takes the oldest received byte.

The serial clock polarity, the clock phase and a four-bit rate code are set in the control and extended control registers. Four chip-select outputs are driven by software only. Each line has an enable bit and a level bit in one register. A second master pulling the peer-select input low while this block is an enabled master is a mode fault. A mode fault latches an error flag, raises the interrupt output and stops new exchanges until software clears the flag.

Register offsets: 0 control, 1 status, 2 data, 3 extended control, 4 parameter, 5 chip select, 6 timing, 7 unused. Control fields: bit 6 core enable, bit 4 master select, bit 3 clock polarity, bit 2 clock phase, bits [1:0] rate code low. Extended control bits [1:0] hold rate code high. Status fields: bit 0 receive empty, bit 1 receive full, bit 2 transmit full, bit 3 transmit empty, bit 4 mode fault, bit 7 busy. Status bits 6 and 5 read 0.

Top module: `bytespi_master`

## Requirements
- R1: After reset, control, extended control and timing read 0x00, parameter reads 0x40, chip select reads 0x00, status reads 0x09, cs_n is 4'b1111, irq is 0 and sck is 0.
- R2: Control, extended control, parameter and timing read back the full byte last written. Offset 7 ignores writes and reads 0x00.
- R3: For each line n from 0 to 3, cs_n[n] is 1 while chip-select bit n (enable) is 0. It equals chip-select bit n+4 (level) while the enable bit is 1. It follows a register write on the next clock.
- R4: Each byte written to the data register, with control bits 6 and 4 set, is shifted out MSB first on mosi. The byte shifted in on miso during the same exchange is appended to the receive queue. Status bit 0 then reads 0, and a read of offset 2 returns the oldest received byte and removes it.
- R5: With no exchange in progress, sck equals control bit 3. With control bit 2 = 0, miso is sampled on the leading sck edge and mosi changes on the trailing edge. With bit 2 = 1, mosi changes on the leading edge and miso is sampled on the trailing edge.
- R6: The rate code is {extended bits [1:0], control bits [1:0]}. It maps to an exponent k: 0→0, 1→1, 4→2, 2→3, 3→4, 5 to 11 map to themselves, and 12 to 15 map to 11. Each sck half period lasts 2^k clock cycles.
- R7: The transmit queue holds 4 bytes, and status bit 2 reads 1 while it is full. A data write made while the queue is full is dropped and never transmitted.
- R8: The receive queue holds 4 bytes, and status bit 1 reads 1 while it is full. No exchange starts while the queue is full, so no received byte is lost. Bytes are read back in the order they were received.
- R9: While control bit 6 or bit 4 is 0, no exchange starts, sck does not toggle and queued transmit bytes are kept.
- R10: A low peer_sel_n while control bits 6 and 4 are both set sets status bit 4 and irq on the next clock. No new exchange starts while the flag is set. Writing status with bit 4 = 1 clears it.
- R11: Reading offset 2 while the receive queue is empty returns 0x00 and changes no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; a read of offset 2 removes the byte it returns |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, valid in the same cycle |
| peer_sel_n | input | 1 | Select input from another master; low while in master mode is a mode fault |
| miso | input | 1 | Serial data in |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| cs_n | output | 4 | Software-driven chip selects |
| irq | output | 1 | Mode-fault interrupt request |

## Verification
The bench runs exchanges in all four clock modes against a slave model. It checks both bytes in every exchange. If the phase were handled wrongly, the bytes would come back shifted by one bit. If the exponent table were misordered, the measured half period would be wrong.

The bench fills the transmit queue while the core is disabled. It checks that a fifth write is lost, and that sck stays quiet until the core is enabled. It then lets the receive queue fill and queues one more byte. If the design did not stall on a full receive queue, it would overwrite or drop a received byte, and the read-back order would break.

The bench raises a mode fault with a byte queued. It checks that the byte stays queued until the flag is cleared. A design that kept shifting would consume the byte early.

// File: rtl/bsp_pkg.sv
`timescale 1ns/1ps
package bsp_pkg;

    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 3;
    localparam int CS_LINES = 4;
    localparam int MAX_LOG  = 11;
    localparam int LOG_W    = 4;

    localparam logic [ADDR_W-1:0] OFS_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_DATA  = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_EXT   = 3'd3;
    localparam logic [ADDR_W-1:0] OFS_PARAM = 3'd4;
    localparam logic [ADDR_W-1:0] OFS_CSEL  = 3'd5;
    localparam logic [ADDR_W-1:0] OFS_TIME  = 3'd6;

    localparam logic [BYTE_W-1:0] PARAM_RESET = 8'h40;

    typedef struct packed {
        logic       spare7;
        logic       enable;
        logic       spare5;
        logic       master;
        logic       cpol;
        logic       cpha;
        logic [1:0] rate_lo;
    } ctrl_t;

    typedef struct packed {
        logic       busy;
        logic [1:0] spare;
        logic       fault;
        logic       tx_empty;
        logic       tx_full;
        logic       rx_full;
        logic       rx_empty;
    } stat_t;

    typedef struct packed {
        logic [CS_LINES-1:0] level;
        logic [CS_LINES-1:0] enable;
    } csel_t;

    // Rate code to half-period exponent.
    function automatic logic [LOG_W-1:0] rate_to_log(input logic [3:0] code);
        logic [LOG_W-1:0] k;
        case (code)
            4'd0:    k = 4'd0;
            4'd1:    k = 4'd1;
            4'd2:    k = 4'd3;
            4'd3:    k = 4'd4;
            4'd4:    k = 4'd2;
            default: k = (code > 4'(MAX_LOG)) ? 4'(MAX_LOG) : code;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/bsp_fifo.sv
`timescale 1ns/1ps
module bsp_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             full,
    output logic             empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wp, rp;
    logic [CW-1:0]    cnt;
    logic             do_push, do_pop;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rp];

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wp] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= nxt(wp);
            if (do_pop)  rp <= nxt(rp);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/bsp_rate_gen.sv
`timescale 1ns/1ps
module bsp_rate_gen
    import bsp_pkg::*;
#(
    parameter int LOG_MAX = MAX_LOG
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [LOG_W-1:0] log_half,
    output logic             tick
);
    localparam int CNTW = (LOG_MAX > 0) ? LOG_MAX : 1;

    logic [CNTW-1:0] cnt;
    logic [CNTW:0]   half_len;

    assign half_len = (CNTW+1)'(1) << log_half;
    assign tick     = run && ({1'b0, cnt} == half_len - (CNTW+1)'(1));

    always_ff @(posedge clk) begin
        if (rst || !run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNTW'(1);
        end
    end

endmodule

// File: rtl/bsp_shifter.sv
`timescale 1ns/1ps
module bsp_shifter #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [DW-1:0] tx_byte,
    input  logic          cpha,
    input  logic          tick,
    input  logic          miso,
    output logic          busy,
    output logic          lvl,
    output logic          mosi,
    output logic          done,
    output logic [DW-1:0] rx_byte
);
    localparam int EDGES = 2 * DW;
    localparam int EW    = $clog2(EDGES);

    logic [DW-1:0] sh;
    logic [EW-1:0] ecnt;
    logic          samp;
    logic          lead, last;

    assign lead = ~ecnt[0];
    assign last = (ecnt == EW'(EDGES - 1));
    assign mosi = sh[DW-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            lvl     <= 1'b0;
            ecnt    <= '0;
            sh      <= '0;
            samp    <= 1'b0;
            done    <= 1'b0;
            rx_byte <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy <= 1'b1;
                    sh   <= tx_byte;
                    ecnt <= '0;
                    lvl  <= 1'b0;
                end
            end else if (tick) begin
                lvl  <= ~lvl;
                ecnt <= ecnt + EW'(1);
                if (lead) begin
                    if (!cpha) begin
                        samp <= miso;
                    end else if (ecnt != '0) begin
                        sh <= {sh[DW-2:0], samp};
                    end
                end else begin
                    if (!cpha) begin
                        sh <= {sh[DW-2:0], samp};
                    end else begin
                        samp <= miso;
                    end
                    if (last) begin
                        busy    <= 1'b0;
                        done    <= 1'b1;
                        rx_byte <= cpha ? {sh[DW-2:0], miso} : {sh[DW-2:0], samp};
                    end
                end
            end
        end
    end

endmodule

// File: rtl/bytespi_master.sv
`timescale 1ns/1ps
module bytespi_master
    import bsp_pkg::*;
#(
    parameter int TX_DEPTH = 4,
    parameter int RX_DEPTH = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [BYTE_W-1:0]   reg_wdata,
    output logic [BYTE_W-1:0]   reg_rdata,
    input  logic                peer_sel_n,
    input  logic                miso,
    output logic                sck,
    output logic                mosi,
    output logic [CS_LINES-1:0] cs_n,
    output logic                irq
);
    ctrl_t             ctrl_q;
    csel_t             csel_q;
    logic [BYTE_W-1:0] ext_q, param_q, time_q;
    logic              fault_q;

    logic              tx_full, tx_empty, rx_full, rx_empty;
    logic [BYTE_W-1:0] tx_head, rx_head, rx_new;
    logic              eng_busy, eng_done, eng_lvl, eng_start, tick;
    logic              tx_push, rx_pop, fault_set, fault_clr;
    logic [LOG_W-1:0]  half_log;
    stat_t             stat_w;

    assign tx_push   = reg_wr && (reg_addr == OFS_DATA);
    assign rx_pop    = reg_rd && (reg_addr == OFS_DATA);
    assign fault_set = ctrl_q.enable && ctrl_q.master && !peer_sel_n;
    assign fault_clr = reg_wr && (reg_addr == OFS_STAT) && reg_wdata[4];
    assign eng_start = !eng_busy && !eng_done && ctrl_q.enable && ctrl_q.master
                       && !fault_q && !tx_empty && !rx_full;
    assign half_log  = rate_to_log({ext_q[1:0], ctrl_q.rate_lo});

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            ext_q   <= '0;
            param_q <= PARAM_RESET;
            csel_q  <= '0;
            time_q  <= '0;
            fault_q <= 1'b0;
        end else begin
            if (reg_wr) begin
                case (reg_addr)
                    OFS_CTRL:  ctrl_q  <= ctrl_t'(reg_wdata);
                    OFS_EXT:   ext_q   <= reg_wdata;
                    OFS_PARAM: param_q <= reg_wdata;
                    OFS_CSEL:  csel_q  <= csel_t'(reg_wdata);
                    OFS_TIME:  time_q  <= reg_wdata;
                    default:   ;
                endcase
            end
            fault_q <= fault_set || (fault_q && !fault_clr);
        end
    end

    bsp_fifo #(.WIDTH(BYTE_W), .DEPTH(TX_DEPTH)) tx_q_i (
        .clk(clk), .rst(rst), .push(tx_push), .push_data(reg_wdata),
        .pop(eng_start), .head(tx_head), .full(tx_full), .empty(tx_empty)
    );

    bsp_fifo #(.WIDTH(BYTE_W), .DEPTH(RX_DEPTH)) rx_q_i (
        .clk(clk), .rst(rst), .push(eng_done), .push_data(rx_new),
        .pop(rx_pop), .head(rx_head), .full(rx_full), .empty(rx_empty)
    );

    bsp_rate_gen #(.LOG_MAX(MAX_LOG)) rate_i (
        .clk(clk), .rst(rst), .run(eng_busy), .log_half(half_log), .tick(tick)
    );

    bsp_shifter #(.DW(BYTE_W)) shift_i (
        .clk(clk), .rst(rst), .start(eng_start), .tx_byte(tx_head),
        .cpha(ctrl_q.cpha), .tick(tick), .miso(miso), .busy(eng_busy),
        .lvl(eng_lvl), .mosi(mosi), .done(eng_done), .rx_byte(rx_new)
    );

    assign sck = ctrl_q.cpol ^ eng_lvl;
    assign irq = fault_q;

    generate
        for (genvar n = 0; n < CS_LINES; n++) begin : g_cs
            assign cs_n[n] = csel_q.enable[n] ? csel_q.level[n] : 1'b1;
        end
    endgenerate

    always_comb begin
        stat_w          = '0;
        stat_w.busy     = eng_busy;
        stat_w.fault    = fault_q;
        stat_w.tx_empty = tx_empty;
        stat_w.tx_full  = tx_full;
        stat_w.rx_full  = rx_full;
        stat_w.rx_empty = rx_empty;
    end

    always_comb begin
        case (reg_addr)
            OFS_CTRL:  reg_rdata = ctrl_q;
            OFS_STAT:  reg_rdata = stat_w;
            OFS_DATA:  reg_rdata = rx_empty ? '0 : rx_head;
            OFS_EXT:   reg_rdata = ext_q;
            OFS_PARAM: reg_rdata = param_q;
            OFS_CSEL:  reg_rdata = csel_q;
            OFS_TIME:  reg_rdata = time_q;
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/bsp_checker.sv
`timescale 1ns/1ps
module bsp_checker (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       sck,
    input logic [7:0] ctrl,
    input logic       reg_wr,
    input logic [2:0] reg_addr,
    input logic [7:0] reg_wdata,
    input logic [3:0] cs_n,
    input logic       peer_sel_n,
    input logic       irq,
    input logic       tx_full,
    input logic       tx_pop,
    input logic       rx_full,
    input logic       rx_push,
    input logic       rx_empty
);
    function automatic logic [3:0] cs_from(input logic [7:0] v);
        logic [3:0] r;
        for (int i = 0; i < 4; i++) begin
            r[i] = v[i] ? v[i+4] : 1'b1;
        end
        return r;
    endfunction

    assert_sck_idle_R5: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (sck == ctrl[3]));

    assert_cs_follow_R3: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 3'd5) |=> (cs_n == cs_from($past(reg_wdata))));

    assert_fault_irq_R10: assert property (@(posedge clk) disable iff (rst)
        (ctrl[6] && ctrl[4] && !peer_sel_n) |=> irq);

    assert_fault_stall_R10: assert property (@(posedge clk) disable iff (rst)
        (irq && !busy) |=> !busy);

    assert_disabled_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (!busy && !(ctrl[6] && ctrl[4])) |=> !busy);

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        rx_full |-> !rx_push);

    assert_tx_drop_R7: assert property (@(posedge clk) disable iff (rst)
        (tx_full && !tx_pop) |=> tx_full);

    assert_rx_empty_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (rx_empty && !rx_push) |=> rx_empty);

endmodule

bind bytespi_master bsp_checker chk_i (
    .clk(clk), .rst(rst), .busy(eng_busy), .sck(sck), .ctrl(ctrl_q),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .cs_n(cs_n),
    .peer_sel_n(peer_sel_n), .irq(irq), .tx_full(tx_full), .tx_pop(eng_start),
    .rx_full(rx_full), .rx_push(eng_done), .rx_empty(rx_empty)
);

// File: tb/bytespi_master_tb_top.sv
`timescale 1ns/1ps
module bytespi_master_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       peer_sel_n = 1'b1;
    logic       miso = 1'b0;
    logic       sck, mosi, irq;
    logic [3:0] cs_n;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    bytespi_master dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .peer_sel_n(peer_sel_n), .miso(miso), .sck(sck), .mosi(mosi),
        .cs_n(cs_n), .irq(irq)
    );

    // Slave model
    logic    cpol_m = 1'b0, cpha_m = 1'b0;
    logic [7:0] s_tx = '0, s_sh = '0, s_last = '0;
    int      s_bit = 7, s_nb = 0, s_cnt = 0, s_edges = 0;
    realtime t_prev = 0.0, half_ns = 0.0;

    task automatic s_finish();
        s_last = s_sh;
        s_cnt++;
        s_tx = s_tx + 8'h11;
        s_bit = 7;
        s_nb = 0;
        if (!cpha_m) miso = s_tx[7];
    endtask

    always @(sck) begin
        half_ns = $realtime - t_prev;
        t_prev  = $realtime;
        s_edges++;
        if (sck != cpol_m) begin
            if (!cpha_m) begin
                s_sh = {s_sh[6:0], mosi};
                s_nb++;
            end else if (s_bit >= 0) begin
                miso = s_tx[s_bit];
                s_bit--;
            end
        end else begin
            if (!cpha_m) begin
                if (s_nb == 8) s_finish();
                else if (s_bit > 0) begin
                    s_bit--;
                    miso = s_tx[s_bit];
                end
            end else begin
                s_sh = {s_sh[6:0], mosi};
                s_nb++;
                if (s_nb == 8) s_finish();
            end
        end
    end

    task automatic arm(input logic [7:0] b);
        s_tx = b; s_bit = 7; s_nb = 0; s_sh = '0;
        miso = cpha_m ? 1'b0 : b[7];
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_stat(input int b, input logic v, input string req);
        logic [7:0] s;
        bit ok = 0;
        for (int i = 0; i < 20000 && !ok; i++) begin
            rd(3'd1, s);
            if (s[b] == v) ok = 1;
        end
        chk(req, {31'd0, ok}, 32'd1);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(3'd0, d); chk("R1 ctrl", d, 8'h00);
        rd(3'd1, d); chk("R1 status", d, 8'h09);
        rd(3'd3, d); chk("R1 ext", d, 8'h00);
        rd(3'd4, d); chk("R1 param", d, 8'h40);
        rd(3'd5, d); chk("R1 csel", d, 8'h00);
        rd(3'd6, d); chk("R1 timing", d, 8'h00);
        chk("R1 pins", {cs_n, irq, sck}, {4'hF, 1'b0, 1'b0});
        rd(3'd2, d); chk("R11 empty read", d, 8'h00);
        rd(3'd1, d); chk("R11 status unchanged", d, 8'h09);
    endtask

    task automatic t_regs();
        logic [7:0] d;
        wr(3'd3, 8'hC3); rd(3'd3, d); chk("R2 ext", d, 8'hC3);
        wr(3'd4, 8'hA5); rd(3'd4, d); chk("R2 param", d, 8'hA5);
        wr(3'd6, 8'h3C); rd(3'd6, d); chk("R2 timing", d, 8'h3C);
        wr(3'd0, 8'h8D); rd(3'd0, d); chk("R2 ctrl", d, 8'h8D);
        wr(3'd7, 8'hFF); rd(3'd7, d); chk("R2 offset7", d, 8'h00);
        wr(3'd0, 8'h00); wr(3'd3, 8'h00);
    endtask

    task automatic t_csel();
        wr(3'd5, 8'h21); idle(1); chk("R3 line0 low", cs_n, 4'b1110);
        wr(3'd5, 8'hFF); idle(1); chk("R3 all high", cs_n, 4'b1111);
        wr(3'd5, 8'h0F); idle(1); chk("R3 all low", cs_n, 4'b0000);
        wr(3'd5, 8'hF0); idle(1); chk("R3 none enabled", cs_n, 4'b1111);
        wr(3'd5, 8'h53); idle(1); chk("R3 mixed", cs_n, 4'b1101);
    endtask

    task automatic t_xfer(input logic pol, input logic pha, input logic [3:0] code,
                          input logic [7:0] txb, input logic [7:0] sb, input int half);
        logic [7:0] d;
        cpol_m = pol; cpha_m = pha;
        wr(3'd0, {4'h5, pol, pha, code[1:0]});
        wr(3'd3, {6'd0, code[3:2]});
        arm(sb);
        idle(1);
        chk("R5 sck idle level", {31'd0, sck}, {31'd0, pol});
        wr(3'd2, txb);
        wait_stat(0, 1'b0, "R4 rx empty clears");
        rd(3'd2, d); chk("R4 received byte", d, sb);
        chk("R5 slave got MSB first", s_last, txb);
        chk("R6 half period", int'(half_ns), 4 * half);
        rd(3'd1, d); chk("R4 status after pop", d, 8'h09);
        chk("R5 sck back idle", {31'd0, sck}, {31'd0, pol});
    endtask

    task automatic t_queues();
        logic [7:0] d;
        int e0, c0;
        cpol_m = 0; cpha_m = 0;
        wr(3'd0, 8'h10); wr(3'd3, 8'h00);
        arm(8'h30);
        e0 = s_edges; c0 = s_cnt;
        wr(3'd2, 8'hA0); wr(3'd2, 8'hA1); wr(3'd2, 8'hA2); wr(3'd2, 8'hA3);
        rd(3'd1, d); chk("R7 tx full flag", d, 8'h05);
        wr(3'd2, 8'hA4);
        idle(40);
        rd(3'd1, d); chk("R9 disabled keeps queue", d, 8'h05);
        chk("R9 no sck toggles", s_edges - e0, 0);
        wr(3'd0, 8'h50);
        wait_stat(1, 1'b1, "R8 rx fills");
        rd(3'd1, d); chk("R8 status rx full", d, 8'h0A);
        chk("R7 fifth write dropped", s_cnt - c0, 4);
        chk("R7 last sent", s_last, 8'hA3);
        wr(3'd2, 8'hB0);
        idle(60);
        rd(3'd1, d); chk("R8 stall on rx full", d, 8'h02);
        rd(3'd2, d); chk("R8 order 0", d, 8'h30);
        wait_stat(1, 1'b1, "R8 rx refills");
        rd(3'd2, d); chk("R8 order 1", d, 8'h41);
        rd(3'd2, d); chk("R8 order 2", d, 8'h52);
        rd(3'd2, d); chk("R8 order 3", d, 8'h63);
        rd(3'd2, d); chk("R8 order 4", d, 8'h74);
        chk("R8 stalled byte sent", s_last, 8'hB0);
    endtask

    task automatic t_fault();
        logic [7:0] d;
        int c0;
        cpol_m = 0; cpha_m = 0;
        wr(3'd0, 8'h50);
        arm(8'h9C);
        c0 = s_cnt;
        @(negedge clk); peer_sel_n = 1'b0;
        @(negedge clk); peer_sel_n = 1'b1;
        chk("R10 irq raised", {31'd0, irq}, 32'd1);
        wr(3'd2, 8'hC5);
        idle(40);
        rd(3'd1, d); chk("R10 fault stalls", d, 8'h11);
        chk("R10 nothing sent", s_cnt - c0, 0);
        wr(3'd1, 8'h10);
        idle(1);
        chk("R10 irq cleared", {31'd0, irq}, 32'd0);
        wait_stat(0, 1'b0, "R10 resumes");
        rd(3'd2, d); chk("R10 byte after clear", d, 8'h9C);
        chk("R10 slave got", s_last, 8'hC5);
        rd(3'd2, d); chk("R11 empty read again", d, 8'h00);
        rd(3'd1, d); chk("R11 status still", d, 8'h09);
    endtask

    initial begin
        #(4 * 190000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regs();
        t_csel();
        t_xfer(1'b0, 1'b0, 4'd0, 8'hB6, 8'h5A, 1);
        t_xfer(1'b0, 1'b1, 4'd1, 8'h3C, 8'hE1, 2);
        t_xfer(1'b1, 1'b0, 4'd4, 8'h81, 8'h7E, 4);
        t_xfer(1'b1, 1'b1, 4'd2, 8'h69, 8'hC3, 8);
        t_queues();
        t_fault();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule